// File: doc/BRIEF.md
# Serial Latched Configuration Port

This block receives a configuration word over three wires: serial data, a shift clock and an active-low enable. While the enable is low, each rising edge of the shift clock moves one data bit into a 15-bit shift register. The most significant bit comes first.

The word in use sits in a separate holding latch. The latch takes the shift register contents only when the enable goes from high to low. Because of this, a frame is committed by the falling enable edge that opens the next frame, or by a short low pulse that carries no clocks. The latched word is split into parallel control fields for downstream logic: operating mode, tone code, transmit attenuation, carrier-detect time select, channel select and a transmit mute.

All three serial wires are treated as asynchronous. Each passes through a two-flop synchroniser into the system clock domain, and edges are detected after synchronisation. The shift clock must therefore run well below the system clock. Each level must last several system clock cycles.

Top module: `ser_cfg_port`

## Requirements
- R1: After reset the latched word is all zeros, so mode 0 (power-down) and 0 dB attenuation are selected.
- R2: While the enable is low, each rising edge of the shift clock samples the serial data input. Bits enter most significant bit first, so the first bit of a 15-bit frame ends up in bit 14 of the word.
- R3: Rising edges of the shift clock while the enable is high leave the shift register unchanged.
- R4: The latched word changes only after a high-to-low transition of the enable. A low-to-high transition of the enable leaves it unchanged.
- R5: Bits shifted in during a frame do not change the outputs until the next falling edge of the enable commits them.
- R6: If a frame carries more than 15 shift clocks, only the last 15 bits received are kept.
- R7: The field layout of the word is fixed as follows. Mode is bits 14..12, tone code is bits 11..8 and attenuation is bits 7..4 (in dB, 0 to 15). Carrier-detect time select is bits 3..2, channel select is bit 1 and transmit mute is bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial shift clock; data is sampled on its rising edge |
| ser_dat | input | 1 | Serial data input, most significant bit first |
| ser_en_n | input | 1 | Active-low frame enable; its falling edge commits the shifted word |
| cfg_word | output | 15 | Whole latched word |
| mode | output | 3 | Operating mode field |
| tone | output | 4 | Tone code field |
| tx_atten | output | 4 | Transmit attenuation in dB |
| cd_time | output | 2 | Carrier-detect time select |
| chan_sel | output | 1 | Channel select |
| tx_mute | output | 1 | Transmit mute |

## Verification
The shift register cannot be seen directly. A fault in it, such as a dropped bit, wrong shift direction or a shift taken while the enable is high, appears on the outputs only after the next commit. That is about three system clock cycles after the enable falls. A latch that loads at the wrong moment is visible sooner: the outputs change in the middle of a frame or when the enable rises. The bench therefore checks the outputs both before and after each commit. It also checks every field separately, so a swapped field boundary shows up at the first committed word that has distinct field values.

// File: rtl/ser_cfg_port.sv
module ser_cfg_port #(
  parameter int MODE_W = 3,
  parameter int TONE_W = 4,
  parameter int ATT_W  = 4,
  parameter int CDT_W  = 2,
  parameter int SYNC   = 2
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic                                      ser_clk,
  input  logic                                      ser_dat,
  input  logic                                      ser_en_n,
  output logic [MODE_W+TONE_W+ATT_W+CDT_W+1:0]      cfg_word,
  output logic [MODE_W-1:0]                         mode,
  output logic [TONE_W-1:0]                         tone,
  output logic [ATT_W-1:0]                          tx_atten,
  output logic [CDT_W-1:0]                          cd_time,
  output logic                                      chan_sel,
  output logic                                      tx_mute
);
  localparam int WORD_W = MODE_W + TONE_W + ATT_W + CDT_W + 2;
  localparam int CDT_LO = 2;
  localparam int ATT_LO = CDT_LO + CDT_W;
  localparam int TON_LO = ATT_LO + ATT_W;
  localparam int MOD_LO = TON_LO + TONE_W;

  logic [SYNC:0]     sck_q, en_q;
  logic [SYNC-1:0]   dat_q;
  logic [WORD_W-1:0] sh;
  logic              sck_rise, en_fall, en_low;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_q <= '0;
      en_q  <= '1;
      dat_q <= '0;
    end else begin
      sck_q <= {sck_q[SYNC-1:0], ser_clk};
      en_q  <= {en_q[SYNC-1:0], ser_en_n};
      dat_q <= {dat_q[SYNC-2:0], ser_dat};
    end

  assign sck_rise = sck_q[SYNC-1] & ~sck_q[SYNC];
  assign en_fall  = en_q[SYNC] & ~en_q[SYNC-1];
  assign en_low   = ~en_q[SYNC-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      sh <= '0;
    else if (sck_rise && en_low)
      sh <= {sh[WORD_W-2:0], dat_q[SYNC-1]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      cfg_word <= '0;
    else if (en_fall)
      cfg_word <= sh;

  assign mode     = cfg_word[MOD_LO +: MODE_W];
  assign tone     = cfg_word[TON_LO +: TONE_W];
  assign tx_atten = cfg_word[ATT_LO +: ATT_W];
  assign cd_time  = cfg_word[CDT_LO +: CDT_W];
  assign chan_sel = cfg_word[1];
  assign tx_mute  = cfg_word[0];

  a_r2_sample_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_rise && en_low) |=> (sh[0] == $past(dat_q[SYNC-1])));
  a_r6_keep_last_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_rise && en_low) |=> (sh[WORD_W-1:1] == $past(sh[WORD_W-2:0])));
  a_r3_idle_no_shift: assert property (@(posedge clk) disable iff (!rst_n)
    !en_low |=> $stable(sh));
  a_r4_commit_only_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !en_fall |=> $stable(cfg_word));
  a_r5_frame_invisible: assert property (@(posedge clk) disable iff (!rst_n)
    (en_low && !en_fall) |=> (cfg_word == $past(cfg_word)));
  a_r4_commit_takes_shift: assert property (@(posedge clk) disable iff (!rst_n)
    en_fall |=> (cfg_word == $past(sh)));
endmodule

// File: tb/sim_ser_cfg_port.sv
`timescale 1ns/1ps
module sim_ser_cfg_port;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_dat = 1'b0, ser_en_n = 1'b1;
  logic [14:0] cfg_word;
  logic [2:0] mode;
  logic [3:0] tone, tx_atten;
  logic [1:0] cd_time;
  logic chan_sel, tx_mute;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ser_cfg_port u0 (.clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .ser_en_n(ser_en_n), .cfg_word(cfg_word), .mode(mode), .tone(tone),
    .tx_atten(tx_atten), .cd_time(cd_time), .chan_sel(chan_sel), .tx_mute(tx_mute));

  localparam logic [14:0] VEC [6] = '{15'h7FFF, 15'h5AC3, 15'h0001, 15'h4000, 15'h2A55, 15'h1234};

  task automatic chk(input string req, input logic [14:0] act, input logic [14:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_out(input logic b);
    ser_dat = b; waitc(4);
    ser_clk = 1'b1; waitc(4);
    ser_clk = 1'b0; waitc(4);
  endtask

  task automatic frame(input logic [14:0] w, input int extra_ones);
    ser_en_n = 1'b0; waitc(6);
    for (int i = 0; i < extra_ones; i++) bit_out(1'b1);
    for (int i = 14; i >= 0; i--) bit_out(w[i]);
    ser_en_n = 1'b1; waitc(6);
  endtask

  task automatic commit();
    ser_en_n = 1'b0; waitc(6);
    ser_en_n = 1'b1; waitc(6);
  endtask

  task automatic chk_fields(input logic [14:0] w);
    chk("R7 mode",  {12'd0, mode},     {12'd0, w[14:12]});
    chk("R7 tone",  {11'd0, tone},     {11'd0, w[11:8]});
    chk("R7 atten", {11'd0, tx_atten}, {11'd0, w[7:4]});
    chk("R7 cdt",   {13'd0, cd_time},  {13'd0, w[3:2]});
    chk("R7 chan",  {14'd0, chan_sel}, {14'd0, w[1]});
    chk("R7 mute",  {14'd0, tx_mute},  {14'd0, w[0]});
  endtask

  initial begin
    logic [14:0] prev;
    waitc(4);
    chk("R1 reset word", cfg_word, 15'h0000);
    rst_n = 1'b1; waitc(4);
    chk("R1 after release", cfg_word, 15'h0000);
    chk("R1 atten zero", {11'd0, tx_atten}, 15'h0000);
    prev = 15'h0000;
    foreach (VEC[k]) begin
      frame(VEC[k], 0);
      chk("R5 not yet committed", cfg_word, prev);
      commit();
      chk("R2 committed word", cfg_word, VEC[k]);
      chk_fields(VEC[k]);
      prev = VEC[k];
    end
    // R5: outputs stable in the middle of a frame
    ser_en_n = 1'b0; waitc(6);
    for (int i = 0; i < 7; i++) bit_out(1'b0);
    chk("R5 mid frame", cfg_word, prev);
    for (int i = 0; i < 8; i++) bit_out(1'b1);
    ser_en_n = 1'b1; waitc(6);
    chk("R4 enable rise no effect", cfg_word, prev);
    commit();
    chk("R2 mixed frame", cfg_word, 15'h00FF);
    // R3: clocks while enable high are ignored
    frame(15'h3C3C, 0);
    for (int i = 0; i < 15; i++) bit_out(1'b0);
    commit();
    chk("R3 idle clocks ignored", cfg_word, 15'h3C3C);
    // R6: overlong frame keeps last 15 bits
    frame(15'h0A0A, 5);
    commit();
    chk("R6 last fifteen bits", cfg_word, 15'h0A0A);
    // R4: second commit with no new bits keeps the same word
    commit();
    chk("R4 repeat commit", cfg_word, 15'h0A0A);
    // R1: reset mid-operation returns to zeros
    rst_n = 1'b0; waitc(2);
    chk("R1 reset clears", cfg_word, 15'h0000);
    rst_n = 1'b1; waitc(2);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule